// File: doc/BRIEF.md
# Steering-Bit Serial Slave Port

This block is the slave end of a frame-synchronised serial link to a DSP. The DSP supplies the bit clock and a one-bit frame pulse. In every sample period one word moves in each direction: serial input bits are shifted in most-significant first, and a word is shifted back on the serial output at the same time. A mode input picks one of two word formats. The wide format has 16 bits, and its leading bit steers the word either to the audio path or to a small register file. The narrow format has 8 bits and always carries a companded audio code.

A control word reads or writes one 8-bit register. The contents of the addressed register go back to the DSP inside the same word. For a write, the DSP therefore receives the register's previous value. A period that carries a control word brings in no new audio, so the held receive sample stays at its last value and is presented again. Companding arithmetic, clock recovery and the converters are outside this block. A separate select input marks wide-format audio as companded instead of linear.

Top module: `ssp_steer_port`

## Requirements
- R1: While reset is high on a clock edge, every configuration register, the receive sample and the word strobe clear to zero. The serial output is low after the next falling edge.
- R2: A wide word whose first bit is 0 is linear audio when companding is not selected. One cycle after its sixteenth bit, the receive sample equals the word's lower 15 bits shifted up by one place, and the word strobe is high for exactly one cycle.
- R3: In wide linear mode, the serial output carries the 16-bit transmit sample, most-significant bit first. That sample is captured on the edge that sees the frame pulse, and each bit is driven on the falling edge after the matching input bit is sampled.
- R4: In wide mode with companding selected, the receive sample is the incoming word's low byte, zero-extended. The outgoing word is the transmit sample's low byte followed by eight zero bits.
- R5: With the mode input low, a word is 8 bits. The strobe fires after the eighth bit, the receive sample is the 8-bit code zero-extended, and the outgoing word is the transmit sample's low byte. No register changes, even when the code's top bit is 1.
- R6: A wide word with bit 15 = 1 and bit 14 = 0 is a register write. Bits 13..10 address the register and bits 7..0 hold the data. The register takes the new value one cycle after the sixteenth bit. The outgoing word carries the previous register value in bits 7..0 and zeros in bits 9..8.
- R7: A wide word with bit 15 = 1 and bit 14 = 1 is a register read. Its data field has no effect on any register, and the register's current value appears in bits 7..0 of the outgoing word.
- R8: After a control word, the receive sample keeps the previous audio value, and the strobe still pulses once for that sample period.
- R9: A frame pulse that arrives in the middle of a word starts a new word. The partial word produces no strobe and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock from the DSP. Input is sampled on rising edges and output changes on falling edges. |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1: 16-bit steered words, 0: 8-bit companded words. Captured at the start of each word. |
| comp_sel | input | 1 | In wide mode, marks audio words as companded. Captured at the start of each word. |
| frame_sync | input | 1 | Frame pulse. High on the rising edge that samples a word's first bit. |
| ser_in | input | 1 | Serial data from the DSP |
| ser_out | output | 1 | Serial data to the DSP |
| aud_tx | input | 16 | Transmit sample from the audio path |
| aud_rx | output | 16 | Held receive sample for the audio path |
| aud_rx_valid | output | 1 | One-cycle strobe after each complete word |
| cfg_regs | output | NREG*REG_W | Register file contents, with register k in bits k*REG_W and up |

## Verification
The bench sends back-to-back write words to one register and checks that each reply carries the value that register held before the write. A design that samples the register at the end of the word, or echoes the new data, would return the wrong byte. The bench also sends a read word with a nonzero data field and checks the register at its output afterwards. This catches a design that writes regardless of the read flag. A control word that follows an audio word must leave the receive sample unchanged, which exposes a design that loads the control bits as audio. Narrow words with the top bit set, and frame pulses cut in mid-word, must cause no register write, which catches decoding that ignores the mode or that completes a partial word.

// File: rtl/sspt_pkg.sv
package sspt_pkg;

    localparam int WORD_W   = 16;
    localparam int NARROW_W = 8;
    localparam int CNT_W    = $clog2(WORD_W + 1);

    // Field layout of a wide control word
    typedef struct packed {
        logic       steer;   // 1: control access
        logic       rnw;     // 1: read only
        logic [3:0] addr;
        logic [1:0] pad;
        logic [7:0] data;
    } ctl_word_t;

    // Sample handed to the audio path from a received word
    function automatic logic [WORD_W-1:0] rx_audio(input logic wide,
                                                   input logic comp,
                                                   input logic [WORD_W-1:0] w);
        if (wide && !comp)
            return {w[WORD_W-2:0], 1'b0};
        else
            return {8'h00, w[7:0]};
    endfunction

    // Word to shift out, built from the audio transmit sample
    function automatic logic [WORD_W-1:0] tx_frame(input logic wide,
                                                   input logic comp,
                                                   input logic [WORD_W-1:0] s);
        if (wide && !comp)
            return s;
        else
            return {s[7:0], 8'h00};
    endfunction

endpackage

// File: rtl/ssp_rx_frame.sv
module ssp_rx_frame
    import sspt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic              ser_in,
    input  logic              wide_mode,
    input  logic              comp_sel,
    output logic              busy,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              wide_q,
    output logic              comp_q,
    output logic              word_fire,
    output logic [WORD_W-1:0] full_word,
    output logic              addr_hit,
    output logic [3:0]        peek_addr
);
    // Number of bits received before the last address bit arrives
    localparam int ADDR_LAST = 5;

    logic [WORD_W-1:0] shift_q;
    logic [CNT_W-1:0]  word_len;
    logic [CNT_W-1:0]  cnt_next;
    logic              steer_seen;

    assign word_len = wide_q ? CNT_W'(WORD_W) : CNT_W'(NARROW_W);
    assign cnt_next = bit_cnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
            shift_q <= '0;
            wide_q  <= 1'b1;
            comp_q  <= 1'b0;
        end else if (frame_sync) begin
            busy    <= 1'b1;
            bit_cnt <= CNT_W'(1);
            shift_q <= {{(WORD_W-1){1'b0}}, ser_in};
            wide_q  <= wide_mode;
            comp_q  <= comp_sel;
        end else if (busy) begin
            shift_q <= {shift_q[WORD_W-2:0], ser_in};
            bit_cnt <= cnt_next;
            if (cnt_next == word_len)
                busy <= 1'b0;
        end
    end

    assign word_fire  = !frame_sync && busy && (cnt_next == word_len);
    assign full_word  = wide_q ? {shift_q[WORD_W-2:0], ser_in}
                               : {8'h00, shift_q[6:0], ser_in};
    assign steer_seen = shift_q[4];
    assign peek_addr  = {shift_q[2:0], ser_in};
    assign addr_hit   = !frame_sync && busy && wide_q && steer_seen
                        && (bit_cnt == CNT_W'(ADDR_LAST));
endmodule

// File: rtl/ssp_regfile.sv
module ssp_regfile #(
    parameter int NREG  = 16,
    parameter int REG_W = 8,
    localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [REG_W-1:0]      rd_data,
    output logic [NREG*REG_W-1:0] flat
);
    logic [REG_W-1:0] regs [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[k] <= '0;
            else if (wr_en && (wr_addr == AW'(k)))
                regs[k] <= wr_data;
        end
        assign flat[k*REG_W +: REG_W] = regs[k];
    end

    assign rd_data = (int'(rd_addr) < NREG) ? regs[rd_addr] : '0;
endmodule

// File: rtl/ssp_tx_shift.sv
module ssp_tx_shift
    import sspt_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic              wide_mode,
    input  logic              comp_sel,
    input  logic [WORD_W-1:0] aud_tx,
    input  logic              busy,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              addr_hit,
    input  logic [REG_W-1:0]  rd_data,
    output logic              ser_out
);
    logic [WORD_W-1:0] tx_word;
    logic              drive_en;
    logic [3:0]        drive_idx;

    // Word load at frame start; read-back inserted once the address is known
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_word <= '0;
        end else if (frame_sync) begin
            tx_word <= tx_frame(wide_mode, comp_sel, aud_tx);
        end else if (addr_hit) begin
            tx_word[9:0] <= {2'b00, 8'(rd_data)};
        end
    end

    // Index of the bit sampled on this rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            drive_en  <= 1'b0;
            drive_idx <= '0;
        end else if (frame_sync) begin
            drive_en  <= 1'b1;
            drive_idx <= 4'd15;
        end else if (busy) begin
            drive_en  <= 1'b1;
            drive_idx <= 4'd15 - bit_cnt[3:0];
        end else begin
            drive_en  <= 1'b0;
        end
    end

    always_ff @(negedge clk) begin
        if (rst)
            ser_out <= 1'b0;
        else
            ser_out <= drive_en ? tx_word[drive_idx] : 1'b0;
    end
endmodule

// File: rtl/ssp_steer_port.sv
module ssp_steer_port
    import sspt_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int REG_W = 8
) (
    input  logic                  bit_clk,
    input  logic                  rst,
    input  logic                  wide_mode,
    input  logic                  comp_sel,
    input  logic                  frame_sync,
    input  logic                  ser_in,
    output logic                  ser_out,
    input  logic [15:0]           aud_tx,
    output logic [15:0]           aud_rx,
    output logic                  aud_rx_valid,
    output logic [NREG*REG_W-1:0] cfg_regs
);
    localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

    logic              busy;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wide_q;
    logic              comp_q;
    logic              word_fire;
    logic [WORD_W-1:0] full_word;
    logic              addr_hit;
    logic [3:0]        peek_addr;
    logic [REG_W-1:0]  rd_data;
    ctl_word_t         ctl;
    logic              fire_ctl;
    logic              fire_rnw;
    logic              wr_en;

    ssp_rx_frame u_rx (
        .clk        (bit_clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .ser_in     (ser_in),
        .wide_mode  (wide_mode),
        .comp_sel   (comp_sel),
        .busy       (busy),
        .bit_cnt    (bit_cnt),
        .wide_q     (wide_q),
        .comp_q     (comp_q),
        .word_fire  (word_fire),
        .full_word  (full_word),
        .addr_hit   (addr_hit),
        .peek_addr  (peek_addr)
    );

    assign ctl      = ctl_word_t'(full_word);
    assign fire_ctl = word_fire && wide_q && ctl.steer;
    assign fire_rnw = ctl.rnw;
    assign wr_en    = fire_ctl && !ctl.rnw;

    ssp_regfile #(.NREG(NREG), .REG_W(REG_W)) u_regs (
        .clk     (bit_clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (AW'(ctl.addr)),
        .wr_data (REG_W'(ctl.data)),
        .rd_addr (AW'(peek_addr)),
        .rd_data (rd_data),
        .flat    (cfg_regs)
    );

    ssp_tx_shift #(.REG_W(REG_W)) u_tx (
        .clk        (bit_clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .wide_mode  (wide_mode),
        .comp_sel   (comp_sel),
        .aud_tx     (aud_tx),
        .busy       (busy),
        .bit_cnt    (bit_cnt),
        .addr_hit   (addr_hit),
        .rd_data    (rd_data),
        .ser_out    (ser_out)
    );

    // Held receive sample; control periods re-present the previous one
    always_ff @(posedge bit_clk) begin
        if (rst) begin
            aud_rx       <= '0;
            aud_rx_valid <= 1'b0;
        end else begin
            aud_rx_valid <= word_fire;
            if (word_fire && !fire_ctl)
                aud_rx <= rx_audio(wide_q, comp_q, full_word);
        end
    end
endmodule

// File: rtl/ssp_steer_port_chk.sv
module ssp_steer_port_chk #(
    parameter int NREG  = 16,
    parameter int REG_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NREG*REG_W-1:0] cfg,
    input logic                  valid,
    input logic [15:0]           rx,
    input logic                  fire,
    input logic                  fire_ctl,
    input logic                  fire_rnw,
    input logic                  wide_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cfg == '0) && !valid && (rx == '0)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) valid |=> !valid); // R2

    AST_NARROW_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (fire && !wide_q) |=> $stable(cfg)); // R5

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (fire_ctl && fire_rnw) |=> $stable(cfg)); // R7

    AST_CTRL_HOLDS_SAMPLE: assert property (@(posedge clk) disable iff (rst) fire_ctl |=> $stable(rx) && valid); // R8

    AST_PARTIAL_NO_STROBE: assert property (@(posedge clk) disable iff (rst) !fire |=> !valid); // R9
endmodule

bind ssp_steer_port ssp_steer_port_chk #(.NREG(NREG), .REG_W(REG_W)) u_chk (
    .clk      (bit_clk),
    .rst      (rst),
    .cfg      (cfg_regs),
    .valid    (aud_rx_valid),
    .rx       (aud_rx),
    .fire     (word_fire),
    .fire_ctl (fire_ctl),
    .fire_rnw (fire_rnw),
    .wide_q   (wide_q)
);

// File: tb/tb_ssp_steer_port.sv
`timescale 1ns/1ps
module tb_ssp_steer_port;
    localparam int NREG  = 16;
    localparam int REG_W = 8;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  wide_mode = 1'b1;
    logic                  comp_sel = 1'b0;
    logic                  frame_sync = 1'b0;
    logic                  ser_in = 1'b0;
    logic                  ser_out;
    logic [15:0]           aud_tx = '0;
    logic [15:0]           aud_rx;
    logic                  aud_rx_valid;
    logic [NREG*REG_W-1:0] cfg_regs;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ssp_steer_port #(.NREG(NREG), .REG_W(REG_W)) dut (
        .bit_clk      (clk),
        .rst          (rst),
        .wide_mode    (wide_mode),
        .comp_sel     (comp_sel),
        .frame_sync   (frame_sync),
        .ser_in       (ser_in),
        .ser_out      (ser_out),
        .aud_tx       (aud_tx),
        .aud_rx       (aud_rx),
        .aud_rx_valid (aud_rx_valid),
        .cfg_regs     (cfg_regs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int k);
        return cfg_regs[k*REG_W +: REG_W];
    endfunction

    // Shift nbits of w (from bit 15 down); returns the reply bits and strobe
    task automatic xfer(input logic [15:0] w, input int nbits,
                        output logic [15:0] got, output logic vld);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); #1;
            if (i > 0) got[16-i] = ser_out;
            frame_sync = (i == 0);
            ser_in     = w[15-i];
        end
        @(negedge clk); #1;
        got[16-nbits] = ser_out;
        frame_sync = 1'b0;
        ser_in     = 1'b0;
        vld        = aud_rx_valid;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1 cfg", 32'(cfg_regs != '0), 0);
        check("R1 aud_rx", 32'(aud_rx), 0);
        check("R1 valid", 32'(aud_rx_valid), 0);
        check("R1 ser_out", 32'(ser_out), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_wide_audio();
        logic [15:0] got; logic v;
        wide_mode = 1; comp_sel = 0;
        aud_tx = 16'hBEEF;
        xfer(16'h1234, 16, got, v);
        check("R2 rx", 32'(aud_rx), 32'h2468);
        check("R2 strobe", 32'(v), 1);
        check("R3 tx", 32'(got), 32'hBEEF);
        @(negedge clk); #1;
        check("R2 strobe one cycle", 32'(aud_rx_valid), 0);
        aud_tx = 16'h8001;
        xfer(16'h7FFF, 16, got, v);
        check("R2 rx", 32'(aud_rx), 32'hFFFE);
        check("R3 tx", 32'(got), 32'h8001);
    endtask

    task automatic t_comp_wide();
        logic [15:0] got; logic v;
        wide_mode = 1; comp_sel = 1;
        aud_tx = 16'h12A7;
        xfer(16'h00C3, 16, got, v);
        check("R4 rx", 32'(aud_rx), 32'h00C3);
        check("R4 tx", 32'(got), 32'hA700);
        comp_sel = 0;
    endtask

    task automatic t_narrow();
        logic [15:0] got; logic v;
        wide_mode = 0;
        aud_tx = 16'h0056;
        xfer(16'h9B00, 8, got, v);
        check("R5 rx", 32'(aud_rx), 32'h009B);
        check("R5 strobe", 32'(v), 1);
        check("R5 tx", 32'(got[15:8]), 32'h56);
        check("R5 no reg write", 32'(cfg_regs != '0), 0);
        aud_tx = 16'h00F1;
        xfer(16'hCC00, 8, got, v);
        check("R5 rx top bit", 32'(aud_rx), 32'h00CC);
        check("R5 tx", 32'(got[15:8]), 32'hF1);
        check("R5 no reg write", 32'(cfg_regs != '0), 0);
        wide_mode = 1;
    endtask

    task automatic t_write();
        logic [15:0] got; logic v;
        aud_tx = 16'hFC00;
        xfer(16'h8CA5, 16, got, v);
        check("R6 old value", 32'(got), 32'hFC00);
        check("R6 reg3", 32'(reg_at(3)), 32'hA5);
        xfer(16'h8C3C, 16, got, v);
        check("R6 old value", 32'(got), 32'hFCA5);
        check("R6 reg3", 32'(reg_at(3)), 32'h3C);
        xfer(16'hBC7E, 16, got, v);
        check("R6 old value reg15", 32'(got), 32'hFC00);
        check("R6 reg15", 32'(reg_at(15)), 32'h7E);
        check("R6 reg14 untouched", 32'(reg_at(14)), 0);
    endtask

    task automatic t_read();
        logic [15:0] got; logic v;
        aud_tx = 16'h0300;
        xfer(16'hCCFF, 16, got, v);
        check("R7 read value", 32'(got), 32'h003C);
        check("R7 reg3 kept", 32'(reg_at(3)), 32'h3C);
    endtask

    task automatic t_hold();
        logic [15:0] got; logic v;
        xfer(16'h0555, 16, got, v);
        check("R8 audio first", 32'(aud_rx), 32'h0AAA);
        xfer(16'h8811, 16, got, v);
        check("R8 held sample", 32'(aud_rx), 32'h0AAA);
        check("R8 strobe", 32'(v), 1);
        check("R8 reg2 written", 32'(reg_at(2)), 32'h11);
    endtask

    task automatic t_restart();
        logic [15:0] got; logic v;
        xfer(16'h8433, 9, got, v);
        check("R9 no strobe", 32'(v), 0);
        xfer(16'h0101, 16, got, v);
        check("R9 new word", 32'(aud_rx), 32'h0202);
        check("R9 strobe", 32'(v), 1);
        check("R9 reg1 untouched", 32'(reg_at(1)), 0);
    endtask

    initial begin
        t_reset();
        t_wide_audio();
        t_comp_wide();
        t_narrow();
        t_write();
        t_read();
        t_hold();
        t_restart();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule